// File: doc/BRIEF.md
# Slack-Gated SMT Fetch Selector

This block picks, each cycle, which of the two hardware threads sharing one simultaneously multithreaded core may fetch. Thread 0 is the leading copy of application A. Thread 1 is the trailing copy of a different application B, whose leading copy runs on a neighbouring core. For each application the block keeps a slack count: the number of leader commits not yet matched by a trailer commit. It updates the count from per-cycle commit pulses.

Each thread passes two gates before arbitration. A trailer whose application has too little slack would reach loads whose values are not queued yet, so it is held back. A leader whose application has too much slack would overflow the result queue, so it is held back too. The two bounds are inputs. In practice the lower bound is set to the trailer's reorder-buffer size, and the upper bound to the result-queue depth minus the leader's reorder-buffer size.

When both threads pass their gates and are ready, the thread with fewer instructions in its front end wins. An exact tie alternates between the threads. The grant is registered.

Top module: `slack_fetch_sel`

## Requirements
- R1: The trailing thread (grant bit 1) is never granted while application B's slack is below `lo_thresh`. A slack equal to `lo_thresh` does not gate it.
- R2: The leading thread (grant bit 0) is never granted while application A's slack is above `hi_thresh`. A slack equal to `hi_thresh` does not gate it.
- R3: When both threads are eligible, the thread with the strictly smaller front-end instruction count is granted.
- R4: When both threads are eligible and their counts are equal, the grant alternates between them. The first such tie after reset goes to the leading thread.
- R5: A thread whose ready flag is low is never granted. When neither thread is eligible, `grant` is 2'b00.
- R6: Each application's slack rises by one on a cycle with only a leader commit and falls by one on a cycle with only a trailer commit. It is unchanged when both or neither commit. After reset, both slacks are zero.
- R7: Slack saturates. It stays at 2^SLACK_W-1 on further leader commits and stays at 0 on further trailer commits.
- R8: `grant` is a register and is zero during reset. It holds at most one set bit: bit 0 is the leading thread and bit 1 is the trailing thread. It is computed from the inputs of the previous cycle and from the slack as it stood before that cycle's commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_commit_a | input | 1 | Leader of application A committed an instruction |
| trail_commit_a | input | 1 | Trailer of application A committed an instruction |
| lead_commit_b | input | 1 | Leader of application B committed an instruction |
| trail_commit_b | input | 1 | Trailer of application B committed an instruction |
| lo_thresh | input | SLACK_W | Minimum slack for the trailer to fetch |
| hi_thresh | input | SLACK_W | Maximum slack for the leader to fetch |
| icnt_lead | input | ICNT_W | Front-end instruction count of thread 0 |
| icnt_trail | input | ICNT_W | Front-end instruction count of thread 1 |
| rdy_lead | input | 1 | Thread 0 is able to fetch |
| rdy_trail | input | 1 | Thread 1 is able to fetch |
| grant | output | 2 | One-hot fetch grant, or zero for no grant |

## Verification
The bench builds the block with SLACK_W=4 and ICNT_W=4. Bounds of 3 and 10 are driven on the threshold ports. The narrow slack makes the ceiling of 15 reachable in about twenty commits. A counter that wrapped instead of saturating would then show up as a wrong gate decision at the ports. The small bounds also put both gate edges, slack equal to a bound and one past it, within a few commit pulses.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int THR_LEAD  = 0;
    localparam int THR_TRAIL = 1;
    localparam int NUM_APPS  = 2;

    typedef struct packed {
        logic [1:0] grant;
        logic       tie_pref;
    } arb_state_t;

endpackage

// File: rtl/slack_counter.sv
module slack_counter #(
    parameter int SLACK_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lead_commit,
    input  logic               trail_commit,
    output logic [SLACK_W-1:0] slack
);

    localparam logic [SLACK_W-1:0] CEIL = '1;

    logic [SLACK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({lead_commit, trail_commit})
            2'b10:   if (cnt_q != CEIL) cnt_d = cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slack = cnt_q;

    AST_SLACK_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CEIL && lead_commit && !trail_commit) |=> (cnt_q == CEIL)); // R7
    AST_SLACK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && trail_commit && !lead_commit) |=> (cnt_q == '0)); // R7
    AST_SLACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_commit == trail_commit) |=> $stable(cnt_q)); // R6
    AST_SLACK_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_commit && !trail_commit && cnt_q != CEIL) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/fetch_arbiter.sv
module fetch_arbiter
    import sfs_pkg::*;
#(
    parameter int SLACK_W = 12,
    parameter int ICNT_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLACK_W-1:0] slack_lead_app,
    input  logic [SLACK_W-1:0] slack_trail_app,
    input  logic [SLACK_W-1:0] lo_thresh,
    input  logic [SLACK_W-1:0] hi_thresh,
    input  logic [ICNT_W-1:0]  icnt_lead,
    input  logic [ICNT_W-1:0]  icnt_trail,
    input  logic               rdy_lead,
    input  logic               rdy_trail,
    output logic [1:0]         grant
);

    arb_state_t state_d, state_q;
    logic       elig_lead, elig_trail;

    always_comb begin
        elig_lead  = rdy_lead  && (slack_lead_app  <= hi_thresh);
        elig_trail = rdy_trail && (slack_trail_app >= lo_thresh);

        state_d       = state_q;
        state_d.grant = '0;
        if (elig_lead && elig_trail) begin
            if (icnt_lead < icnt_trail) begin
                state_d.grant[THR_LEAD] = 1'b1;
            end else if (icnt_trail < icnt_lead) begin
                state_d.grant[THR_TRAIL] = 1'b1;
            end else begin
                state_d.grant[state_q.tie_pref] = 1'b1;
                state_d.tie_pref                = ~state_q.tie_pref;
            end
        end else if (elig_lead) begin
            state_d.grant[THR_LEAD] = 1'b1;
        end else if (elig_trail) begin
            state_d.grant[THR_TRAIL] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign grant = state_q.grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_TRAIL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (slack_trail_app < lo_thresh) |=> !grant[THR_TRAIL]); // R1
    AST_LEAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (slack_lead_app > hi_thresh) |=> !grant[THR_LEAD]); // R2
    AST_ICOUNT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_lead && rdy_trail && slack_lead_app <= hi_thresh &&
         slack_trail_app >= lo_thresh && icnt_lead < icnt_trail) |=> grant[THR_LEAD]); // R3
    AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_lead && !rdy_trail) |=> (grant == 2'b00)); // R5

endmodule

// File: rtl/slack_fetch_sel.sv
module slack_fetch_sel
    import sfs_pkg::*;
#(
    parameter int SLACK_W = 12,
    parameter int ICNT_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lead_commit_a,
    input  logic               trail_commit_a,
    input  logic               lead_commit_b,
    input  logic               trail_commit_b,
    input  logic [SLACK_W-1:0] lo_thresh,
    input  logic [SLACK_W-1:0] hi_thresh,
    input  logic [ICNT_W-1:0]  icnt_lead,
    input  logic [ICNT_W-1:0]  icnt_trail,
    input  logic               rdy_lead,
    input  logic               rdy_trail,
    output logic [1:0]         grant
);

    logic [NUM_APPS-1:0] lead_c, trail_c;
    logic [SLACK_W-1:0]  slack [NUM_APPS];

    assign lead_c  = {lead_commit_b, lead_commit_a};
    assign trail_c = {trail_commit_b, trail_commit_a};

    for (genvar g = 0; g < NUM_APPS; g++) begin : g_app
        slack_counter #(.SLACK_W(SLACK_W)) u_slack (
            .clk          (clk),
            .rst_n        (rst_n),
            .lead_commit  (lead_c[g]),
            .trail_commit (trail_c[g]),
            .slack        (slack[g])
        );
    end

    // Thread 0 leads application A; thread 1 trails application B.
    fetch_arbiter #(.SLACK_W(SLACK_W), .ICNT_W(ICNT_W)) u_arb (
        .clk             (clk),
        .rst_n           (rst_n),
        .slack_lead_app  (slack[0]),
        .slack_trail_app (slack[1]),
        .lo_thresh       (lo_thresh),
        .hi_thresh       (hi_thresh),
        .icnt_lead       (icnt_lead),
        .icnt_trail      (icnt_trail),
        .rdy_lead        (rdy_lead),
        .rdy_trail       (rdy_trail),
        .grant           (grant)
    );

endmodule

// File: tb/tb_slack_fetch_sel.sv
module tb_slack_fetch_sel;

    localparam int SW = 4;
    localparam int IW = 4;
    localparam int SMAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          la = 0, ta = 0, lb = 0, tb_c = 0;
    logic [SW-1:0] lo = 4'd3, hi = 4'd10;
    logic [IW-1:0] il = '0, it = '0;
    logic          rl = 0, rt = 0;
    logic [1:0]    grant;

    int checks = 0, failures = 0;
    int sa = 0, sb = 0, pref = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    slack_fetch_sel #(.SLACK_W(SW), .ICNT_W(IW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lead_commit_a(la), .trail_commit_a(ta),
        .lead_commit_b(lb), .trail_commit_b(tb_c),
        .lo_thresh(lo), .hi_thresh(hi),
        .icnt_lead(il), .icnt_trail(it),
        .rdy_lead(rl), .rdy_trail(rt),
        .grant(grant)
    );

    function automatic int sat(int v);
        if (v < 0) return 0;
        if (v > SMAX) return SMAX;
        return v;
    endfunction

    // Driver: apply one cycle of stimulus, push the expected grant.
    task automatic step(bit ila, bit ita, bit ilb, bit itb, bit irl, bit irt,
                        int iil, int iit, string tag);
        bit el, et;
        logic [1:0] e;
        @(negedge clk);
        la = ila; ta = ita; lb = ilb; tb_c = itb;
        rl = irl; rt = irt; il = IW'(iil); it = IW'(iit);
        el = irl && (sa <= int'(hi));
        et = irt && (sb >= int'(lo));
        e  = 2'b00;
        if (el && et) begin
            if (iil < iit)      e = 2'b01;
            else if (iit < iil) e = 2'b10;
            else begin
                e = (pref == 0) ? 2'b01 : 2'b10;
                pref = 1 - pref;
            end
        end else if (el) e = 2'b01;
        else if (et)     e = 2'b10;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (ila != ita) sa = sat(ila ? sa + 1 : sa - 1);
        if (ilb != itb) sb = sat(ilb ? sb + 1 : sb - 1);
    endtask

    // Monitor: compare each registered grant with the queued expectation.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (grant !== e) begin
                failures++;
                $display("FAIL %s grant=%b expected=%b", t, grant, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog grant=%b expected=finish", grant);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (grant !== 2'b00) begin
            failures++;
            $display("FAIL R8 reset grant=%b expected=00", grant);
        end
        rst_n = 1'b1;

        // R1: trailer gated at slack 0, leader passes
        step(0,0,0,0, 1,1, 2,1, "R1 trailer gated low slack");
        step(0,0,0,0, 0,1, 0,0, "R5 R1 nothing eligible");
        for (int k = 0; k < 3; k++) step(0,0,1,0, 0,1, 0,0, "R1 R8 slack B ramp");
        step(0,0,0,0, 0,1, 0,0, "R1 slack equal lo passes");
        // R3: smaller count wins
        step(0,0,0,0, 1,1, 5,2, "R3 trailer fewer");
        step(0,0,0,0, 1,1, 1,4, "R3 leader fewer");
        // R4: ties alternate
        for (int k = 0; k < 4; k++) step(0,0,0,0, 1,1, 3,3, "R4 tie alternate");
        // R5: not ready
        step(0,0,0,0, 0,0, 0,0, "R5 none ready");
        step(0,0,0,0, 0,1, 9,1, "R5 leader not ready");
        // R6: simultaneous commits hold slack, lone trailer commit drops it
        step(0,0,1,1, 0,1, 0,0, "R6 both commits");
        step(0,0,0,1, 0,1, 0,0, "R6 hold then dec");
        step(0,0,0,0, 0,1, 0,0, "R6 slack B below lo");
        // R2 and R7: drive slack A past hi into the ceiling
        for (int k = 0; k < 20; k++) step(1,0,0,0, 1,0, 0,0, "R2 R7 slack A up");
        step(0,0,0,0, 1,0, 0,0, "R2 leader gated at ceiling");
        for (int k = 0; k < 5; k++) step(0,1,0,0, 1,0, 0,0, "R7 R2 down from ceiling");
        step(0,0,0,0, 1,0, 0,0, "R7 R2 slack equal hi passes");
        // R7: floor on slack B
        for (int k = 0; k < 6; k++) step(0,0,0,1, 0,1, 0,0, "R7 slack B floor");
        step(0,0,1,0, 0,1, 0,0, "R7 up from floor");
        step(0,0,1,0, 0,1, 0,0, "R7 up from floor");
        step(0,0,0,0, 0,1, 0,0, "R7 slack B two gated");
        step(0,0,1,0, 0,1, 0,0, "R7 R8 commit seen next cycle");
        step(0,0,0,0, 0,1, 0,0, "R7 slack B three passes");

        @(negedge clk);
        la = 0; ta = 0; lb = 0; tb_c = 0; rl = 0; rt = 0;
        repeat (3) @(posedge clk);
        #2;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule